// File: doc/BRIEF.md
# Early-Terminating Iterative 32x32 Multiplier

This block multiplies two 32-bit operands over several clock cycles. It consumes the multiplier operand in slices of 16, 12 and 4 bits, one slice per cycle. When the operand is issued, the block works out how many upper bits of the multiplier are only an extension of the bits below them. It then stops after one, two or three slices. Small multipliers therefore finish sooner and free the unit earlier than full-width ones.

A requester presents the operands together with `start_i`, a signed/unsigned select and a long-result select. An operation is taken on a rising clock edge where `start_i` is high and `busy_o` is low. A request made while `busy_o` is high is dropped, so the requester has to hold it until `busy_o` falls. A 32-bit operation returns only the low word. A 64-bit operation returns the low word, and the high word follows one cycle later on its own strobe. A third strobe repeats the low-word strobe one cycle late, for consumers that need one extra cycle of result latency.

Top module: `etm32`

## Requirements
- R1: For a long operation, {`hi_o`,`lo_o`} equals the full 64-bit product: two's-complement operands when `sgn_i`=1, unsigned operands when `sgn_i`=0.
- R2: For a short operation (`long_i`=0), `lo_o` equals bits 31:0 of the product, and `hi_valid_o` does not pulse.
- R3: The multiplier `b_i` is placed in a band. Band 0 applies when bits 31:15 all equal the extension value. Band 1 applies otherwise when bits 31:27 all equal it. Band 2 covers every other value. The extension value is all zeros when unsigned, and either all zeros or all ones when signed.
- R4: If the operation is accepted at clock edge k, `lo_valid_o` is high for the one cycle after edge k+2, k+3 or k+4, for band 0, 1 or 2 respectively.
- R5: For a long operation, `hi_valid_o` is high in the cycle right after the `lo_valid_o` cycle, and `lo_o` holds its value during that cycle.
- R6: `busy_o` is high in the cycle after an acceptance. It falls so that the next operation can be accepted on the edge that loads the last result of the current one: k+2/3/4 for short operations and k+3/4/5 for long ones.
- R7: A `start_i` that is high while `busy_o` is high has no effect on the results or timing of the operation in flight, and it starts no new operation.
- R8: `late_o` is high in exactly the cycle that follows each `lo_valid_o` cycle.
- R9: While reset is applied, `busy_o`, `lo_valid_o`, `hi_valid_o` and `late_o` are low.
- R10: Each result strobe lasts a single cycle, and `lo_valid_o` and `hi_valid_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin an operation |
| sgn_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| long_i | input | 1 | 1 = 64-bit product, 0 = low 32 bits only |
| a_i | input | 32 | Multiplicand |
| b_i | input | 32 | Multiplier (sets the band) |
| busy_o | output | 1 | Unit occupied; requests are dropped |
| lo_valid_o | output | 1 | One-cycle strobe for `lo_o` |
| lo_o | output | 32 | Low product word |
| hi_valid_o | output | 1 | One-cycle strobe for `hi_o` |
| hi_o | output | 32 | High product word |
| late_o | output | 1 | `lo_valid_o` delayed by one cycle |

## Verification
The multiplier operand is chosen to sit just inside or just outside each band boundary: 0x7FFF against 0x8000, 0xFFFF8000, 0x07FFFFFF against 0xF8000000, and also 0, -1 and 0x8000_0000. Each of these is run in both signedness modes. This separates a classifier that treats all-ones as an extension in unsigned mode, or that checks the wrong bit range, from a correct one. It also shows whether the top slice is sign-extended only in signed mode. Pseudo-random operands shaped to each band then compare the product against a full-width reference and the strobe cycles against the band. Held and mistimed requests test where `busy_o` releases and show that requests made while busy are dropped.

// File: rtl/etm_pkg.sv
package etm_pkg;
  typedef enum logic [1:0] {
    BAND_SHORT = 2'd0,
    BAND_MID   = 2'd1,
    BAND_FULL  = 2'd2
  } band_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_LO   = 2'd2,
    ST_HI   = 2'd3
  } state_t;
endpackage

// File: rtl/etm_band.sv
module etm_band
  import etm_pkg::*;
#(
  parameter int W  = 32,
  parameter int C0 = 16,
  parameter int C1 = 12
) (
  input  logic [W-1:0] mplier,
  input  logic         sgn,
  output band_t        band
);
  localparam int SB = C0 - 1;
  localparam int MB = C0 + C1 - 1;

  logic fits_short;
  logic fits_mid;

  // upper bits redundant: all zero, or all one for signed operands
  assign fits_short = ~|mplier[W-1:SB] | (sgn & (&mplier[W-1:SB]));
  assign fits_mid   = ~|mplier[W-1:MB] | (sgn & (&mplier[W-1:MB]));

  always_comb begin
    if (fits_short)    band = BAND_SHORT;
    else if (fits_mid) band = BAND_MID;
    else               band = BAND_FULL;
  end
endmodule

// File: rtl/etm_pp.sv
module etm_pp #(
  parameter int W  = 32,
  parameter int C0 = 16,
  parameter int C1 = 12
) (
  input  logic [2*W-1:0] mcand,
  input  logic [W-1:0]   mplier,
  input  logic [1:0]     sel,
  input  logic           sext,
  output logic [2*W-1:0] pp
);
  localparam int DW = 2 * W;

  logic [DW-1:0] term [3];
  logic [DW-1:0] term_sel;

  for (genvar k = 0; k < 3; k++) begin : g_slice
    localparam int OFF = (k == 0) ? 0  : ((k == 1) ? C0 : C0 + C1);
    localparam int CW  = (k == 0) ? C0 : ((k == 1) ? C1 : W - C0 - C1);
    logic [CW-1:0] bits;
    logic [DW-1:0] wide;
    assign bits    = mplier[OFF+CW-1:OFF];
    // only the final slice of a signed operation carries the sign
    assign wide    = {{(DW-CW){sext & bits[CW-1]}}, bits};
    assign term[k] = wide << OFF;
  end

  always_comb begin
    case (sel)
      2'd0:    term_sel = term[0];
      2'd1:    term_sel = term[1];
      default: term_sel = term[2];
    endcase
    pp = mcand * term_sel;
  end
endmodule

// File: rtl/etm_ctrl.sv
module etm_ctrl
  import etm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       long_i,
  input  band_t      band_i,
  output logic       accept_o,
  output logic       busy_o,
  output logic       calc_o,
  output logic [1:0] step_o,
  output logic       last_o,
  output logic       lo_load_o,
  output logic       hi_load_o
);
  state_t     state_q, state_d;
  logic [1:0] step_q, step_d;
  logic [1:0] lastidx_q, lastidx_d;
  logic       long_q, long_d;
  logic       fin;

  always_comb begin
    fin       = (state_q == ST_HI) || (state_q == ST_LO && !long_q);
    busy_o    = (state_q != ST_IDLE) && !fin;
    accept_o  = start_i && !busy_o;
    calc_o    = (state_q == ST_CALC);
    lo_load_o = (state_q == ST_LO);
    hi_load_o = (state_q == ST_HI);
    last_o    = (step_q == lastidx_q);
    step_o    = step_q;
  end

  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    lastidx_d = lastidx_q;
    long_d    = long_q;
    case (state_q)
      ST_CALC: begin
        step_d = step_q + 2'd1;
        if (last_o) state_d = ST_LO;
      end
      ST_LO: begin
        if (long_q) state_d = ST_HI;
        else        state_d = ST_IDLE;
      end
      ST_HI:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (accept_o) begin
      state_d   = ST_CALC;
      step_d    = 2'd0;
      long_d    = long_i;
      lastidx_d = band_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      step_q    <= 2'd0;
      lastidx_q <= 2'd0;
      long_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      step_q    <= step_d;
      lastidx_q <= lastidx_d;
      long_q    <= long_d;
    end
  end
endmodule

// File: rtl/etm32.sv
module etm32
  import etm_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int SLICE0 = 16,
  parameter int SLICE1 = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sgn_i,
  input  logic             long_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             busy_o,
  output logic             lo_valid_o,
  output logic [WIDTH-1:0] lo_o,
  output logic             hi_valid_o,
  output logic [WIDTH-1:0] hi_o,
  output logic             late_o
);
  localparam int DW = 2 * WIDTH;

  logic rs0_q, rs1_q, rst_s;
  logic accept, calc, last, lo_load, hi_load;
  logic [1:0] step;
  band_t band;

  logic [WIDTH-1:0] a_q, b_q;
  logic             sgn_q;
  logic [DW-1:0]    acc_q, acc_d, mcand, pp;
  logic [WIDTH-1:0] lo_q, hi_q;
  logic             lo_v_q, hi_v_q, late_q;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_s = rs1_q;

  etm_band #(.W(WIDTH), .C0(SLICE0), .C1(SLICE1)) u_band (
    .mplier (b_i),
    .sgn    (sgn_i),
    .band   (band)
  );

  etm_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s),
    .start_i   (start_i),
    .long_i    (long_i),
    .band_i    (band),
    .accept_o  (accept),
    .busy_o    (busy_o),
    .calc_o    (calc),
    .step_o    (step),
    .last_o    (last),
    .lo_load_o (lo_load),
    .hi_load_o (hi_load)
  );

  assign mcand = sgn_q ? {{WIDTH{a_q[WIDTH-1]}}, a_q} : {{WIDTH{1'b0}}, a_q};

  etm_pp #(.W(WIDTH), .C0(SLICE0), .C1(SLICE1)) u_pp (
    .mcand  (mcand),
    .mplier (b_q),
    .sel    (step),
    .sext   (sgn_q & last),
    .pp     (pp)
  );

  assign acc_d = ((step == 2'd0) ? '0 : acc_q) + pp;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      a_q   <= '0;
      b_q   <= '0;
      sgn_q <= 1'b0;
    end else if (accept) begin
      a_q   <= a_i;
      b_q   <= b_i;
      sgn_q <= sgn_i;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)    acc_q <= '0;
    else if (calc) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)       lo_q <= '0;
    else if (lo_load) lo_q <= acc_q[WIDTH-1:0];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)       hi_q <= '0;
    else if (hi_load) hi_q <= acc_q[DW-1:WIDTH];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      lo_v_q <= 1'b0;
      hi_v_q <= 1'b0;
      late_q <= 1'b0;
    end else begin
      lo_v_q <= lo_load;
      hi_v_q <= hi_load;
      late_q <= lo_v_q;
    end
  end

  assign lo_valid_o = lo_v_q;
  assign hi_valid_o = hi_v_q;
  assign lo_o       = lo_q;
  assign hi_o       = hi_q;
  assign late_o     = late_q;
endmodule

// File: rtl/etm32_chk.sv
module etm32_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        lo_valid_o,
  input logic        hi_valid_o,
  input logic        late_o,
  input logic [31:0] lo_o
);
  assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_hi_follows_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_valid_o |-> $past(lo_valid_o));

  assert_lo_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_valid_o |-> $stable(lo_o));

  assert_late_after_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lo_valid_o |=> late_o);

  assert_late_only_after_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    late_o |-> $past(lo_valid_o));

  assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lo_valid_o, hi_valid_o}));

  assert_lo_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lo_valid_o |=> !lo_valid_o);
endmodule

bind etm32 etm32_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_s),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .lo_valid_o (lo_valid_o),
  .hi_valid_o (hi_valid_o),
  .late_o     (late_o),
  .lo_o       (lo_o)
);

// File: tb/etm32_test.sv
`timescale 1ns/1ps
module etm32_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, sgn_i = 1'b0, long_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        busy_o, lo_valid_o, hi_valid_o, late_o;
  logic [31:0] lo_o, hi_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;

  etm32 uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sgn_i(sgn_i), .long_i(long_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .lo_valid_o(lo_valid_o), .lo_o(lo_o),
    .hi_valid_o(hi_valid_o), .hi_o(hi_o), .late_o(late_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b, input logic s);
    if (s) ref_prod = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    else   ref_prod = {32'b0, a} * {32'b0, b};
  endfunction

  // band per R3
  function automatic int ref_band(input logic [31:0] b, input logic s);
    if (b[31:15] == 17'h0 || (s && b[31:15] == 17'h1FFFF)) return 0;
    if (b[31:27] == 5'h0 || (s && b[31:27] == 5'h1F)) return 1;
    return 2;
  endfunction

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic t_reset();
    chk(busy_o == 1'b0, "R9", "busy in reset", 64'(busy_o), 64'h0);
    chk(lo_valid_o == 1'b0 && hi_valid_o == 1'b0, "R9", "valids in reset",
        64'({lo_valid_o, hi_valid_o}), 64'h0);
    chk(late_o == 1'b0, "R9", "late in reset", 64'(late_o), 64'h0);
  endtask

  // one operation; checks value, strobe cycles and pulse counts
  task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic s, input logic lng);
    int lat, lo_at, hi_at, late_at, lo_n, hi_n;
    logic [31:0] lo_v, hi_v;
    logic [63:0] p;
    lo_at = 0; hi_at = 0; late_at = 0; lo_n = 0; hi_n = 0; lo_v = '0; hi_v = '0;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    a_i = a; b_i = b; sgn_i = s; long_i = lng; start_i = 1'b1;
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      if (j == 1) start_i = 1'b0;
      if (lo_valid_o) begin lo_n++; lo_at = j; lo_v = lo_o; end
      if (hi_valid_o) begin hi_n++; hi_at = j; hi_v = hi_o; end
      if (late_o) late_at = j;
    end
    p   = ref_prod(a, b, s);
    lat = ref_band(b, s) + 2;
    if (lng) begin
      chk({hi_v, lo_v} == p, "R1", "64-bit product", {hi_v, lo_v}, p);
      chk(hi_at == lat + 2 && hi_n == 1, "R5", "hi strobe cycle", 64'(hi_at), 64'(lat + 2));
    end else begin
      chk(lo_v == p[31:0], "R2", "32-bit product", 64'(lo_v), 64'(p[31:0]));
      chk(hi_n == 0, "R2", "no hi strobe", 64'(hi_n), 64'h0);
    end
    chk(lo_at == lat + 1, "R3 R4", "lo strobe cycle", 64'(lo_at), 64'(lat + 1));
    chk(late_at == lat + 2, "R8", "late strobe cycle", 64'(late_at), 64'(lat + 2));
    chk(lo_n == 1, "R10", "lo pulse count", 64'(lo_n), 64'h1);
  endtask

  task automatic t_corners();
    logic [31:0] vals [12];
    vals = '{32'h0, 32'hFFFF_FFFF, 32'h0000_7FFF, 32'h8000_0000, 32'h0000_8000,
             32'hFFFF_8000, 32'hFFFF_7FFF, 32'h07FF_FFFF, 32'h0800_0000,
             32'hF800_0000, 32'hF7FF_FFFF, 32'h0000_0001};
    for (int i = 0; i < 12; i++) begin
      for (int m = 0; m < 4; m++) begin
        do_op(32'h8765_4321, vals[i], m[0], m[1]);
        do_op(vals[(i + 5) % 12], vals[i], m[0], m[1]);
      end
    end
  endtask

  task automatic t_sweep();
    logic [31:0] a, b, r2;
    for (int i = 0; i < 60; i++) begin
      rng = next_rng(rng); a = rng;
      rng = next_rng(rng); r2 = rng;
      rng = next_rng(rng);
      case (i % 4)
        0:       b = {{17{r2[0]}}, rng[14:0]};
        1:       b = {{5{r2[0]}}, rng[26:0]};
        default: b = r2;
      endcase
      do_op(a, b, 1'((i / 4) % 2), 1'((i / 2) % 2));
    end
  endtask

  // held request: second op accepted on the edge loading the last result
  task automatic t_throughput(input logic [31:0] b1, input logic s, input logic lng);
    logic [31:0] a1, a2, b2, last_lo;
    int t_free, lo_n, exp_t;
    logic [63:0] p2;
    a1 = 32'h1357_9BDF; a2 = 32'h0246_8ACE; b2 = 32'h0000_0033;
    t_free = 0; lo_n = 0; last_lo = '0;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    a_i = a1; b_i = b1; sgn_i = s; long_i = lng; start_i = 1'b1;
    for (int j = 1; j <= 16; j++) begin
      @(negedge clk);
      if (j == 1) begin a_i = a2; b_i = b2; long_i = 1'b0; end
      if (lo_valid_o) begin lo_n++; last_lo = lo_o; end
      if (t_free == 0 && !busy_o) t_free = j;
      else if (t_free != 0 && j == t_free + 1) start_i = 1'b0;
    end
    start_i = 1'b0;
    exp_t = ref_band(b1, s) + 2 + (lng ? 1 : 0);
    p2 = ref_prod(a2, b2, s);
    chk(t_free == exp_t, "R6", "busy release cycle", 64'(t_free), 64'(exp_t));
    chk(lo_n == 2 && last_lo == p2[31:0], "R6", "queued op result", 64'(last_lo), 64'(p2[31:0]));
  endtask

  // request during busy must be dropped
  task automatic t_ignore();
    logic [31:0] a1, b1;
    logic [31:0] lo_v, hi_v;
    int lo_n, lo_at;
    logic [63:0] p;
    a1 = 32'hDEAD_BEEF; b1 = 32'h9ABC_DEF0; lo_n = 0; lo_at = 0; lo_v = '0; hi_v = '0;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    a_i = a1; b_i = b1; sgn_i = 1'b1; long_i = 1'b1; start_i = 1'b1;
    for (int j = 1; j <= 14; j++) begin
      @(negedge clk);
      if (j == 1) begin a_i = 32'h1111_1111; b_i = 32'h0000_0002; long_i = 1'b0; end
      if (j == 3) start_i = 1'b0;
      if (lo_valid_o) begin lo_n++; lo_at = j; lo_v = lo_o; end
      if (hi_valid_o) hi_v = hi_o;
    end
    p = ref_prod(a1, b1, 1'b1);
    chk(lo_n == 1, "R7", "only one result", 64'(lo_n), 64'h1);
    chk({hi_v, lo_v} == p, "R7", "in-flight result intact", {hi_v, lo_v}, p);
    chk(lo_at == 5, "R7", "in-flight timing intact", 64'(lo_at), 64'h5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_corners();
    t_sweep();
    for (int m = 0; m < 4; m++) begin
      t_throughput(32'h0000_1234, m[0], m[1]);
      t_throughput(32'h0123_4567, m[0], m[1]);
      t_throughput(32'h7654_3210, m[0], m[1]);
    end
    t_ignore();
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule